// File: doc/BRIEF.md
# Programmable chip-select read sequencer

This block drives the read strobes for a simple asynchronous memory or peripheral on a local bus where address and data share the same pins. When a read is requested for one of several banks, the sequencer raises the address latch enable for one bus clock. It then turns the shared bus toward the device and asserts that bank's chip-select and the output enable after a programmable fraction of a bus clock. It waits a programmed number of bus clocks, or for a ready signal from the device, and then produces a one-cycle internal transfer acknowledge. The returned data is captured as that acknowledge ends. Chip-select and output enable are released together. An optional idle bus clock follows before the bus direction control returns high, which gives the device extra data hold time.

The block runs on a fast clock. One bus clock is `PH` fast ticks (default 4), so a quarter of a bus clock is one tick. Each bank's timing comes from a 9-bit attribute slice of `bank_cfg`:
- bits [1:0]: chip-select delay.
- bits [5:2]: wait-state count.
- bit 6: relaxed timing.
- bit 7: extended hold.
- bit 8: external acknowledge.

Until `cfg_ready` is high, bank 0 uses a built-in boot attribute set, so a boot memory can be read before configuration.

States and transitions:
- IDLE → ADDR when `rd_req` is high. The bank and its attributes are latched at this point.
- ADDR → CSDLY or ACTIVE after `PH` ticks. The path goes to ACTIVE directly when the delay is zero.
- CSDLY → ACTIVE after the delay ticks.
- ACTIVE → ACK when the wait count expires, or in external mode when ready is seen at the end of a bus clock. Otherwise ACTIVE → ACTIVE for another bus clock.
- ACK → HOLD when extended hold is set, otherwise ACK → TURN.
- HOLD → TURN after `PH` ticks.
- TURN → IDLE.

Top module: `csrs_top`

## Requirements
- R1: During and right after reset, all `cs_n` bits are 1, `oe_n` is 1, `ale` is 0, `dir_ctl` is 1, `xfer_ack` is 0 and `rd_valid` is 0.
- R2: A request taken in idle raises `ale` for exactly `PH` ticks, with `dir_ctl` high. `dir_ctl` falls in the tick `ale` falls, and that tick starts the access.
- R3: Chip-select delay field (bits [1:0]): 2'b10 asserts chip-select `PH/4` ticks after `ale` falls, 2'b11 asserts it `PH/2` ticks after, and 2'b00 or 2'b01 asserts it in the same tick `ale` falls.
- R4: During an access only the `cs_n` bit indexed by the requested bank goes low. All other bits stay high throughout.
- R5: `oe_n` is low in exactly the ticks where some `cs_n` bit is low.
- R6: With external acknowledge clear, chip-select is active for `PH*(1+W)` ticks before `xfer_ack`. W is the wait field (bits [5:2]), doubled when relaxed timing (bit 6) is 1.
- R7: With external acknowledge (bit 8) set, the wait field is ignored. `ext_rdy` is sampled at the last tick of each bus clock of the active phase, and `xfer_ack` follows the first bus clock in which it is seen high.
- R8: `xfer_ack` lasts one tick with chip-select still asserted. `bus_in` from that tick appears on `rd_data` with a one-tick `rd_valid` pulse in the next tick.
- R9: Chip-select and output enable deassert right after the acknowledge. `dir_ctl` stays low for 1 more tick, or for `PH+1` ticks when extended hold (bit 7) is set, then returns high.
- R10: While `cfg_ready` is 0, bank 0 uses the boot attributes (delay 2'b11, wait 3, extended hold on). Other banks always use `bank_cfg`.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, `PH` ticks per bus clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_ready | input | 1 | bank 0 attributes in `bank_cfg` are valid |
| bank_cfg | input | NBANK*9 | per-bank attribute slices |
| rd_req | input | 1 | read request, sampled in idle |
| rd_bank | input | log2(NBANK) | bank to read |
| ext_rdy | input | 1 | device ready for external acknowledge |
| bus_in | input | DW | data returned on the shared bus |
| ale | output | 1 | address latch enable |
| cs_n | output | NBANK | active-low chip-selects |
| oe_n | output | 1 | active-low output enable |
| dir_ctl | output | 1 | bus direction control, high while driving the address |
| xfer_ack | output | 1 | internal transfer acknowledge |
| rd_data | output | DW | captured read data |
| rd_valid | output | 1 | `rd_data` updated |

## Verification
The assertions take for granted that `rd_bank` and `bank_cfg` only change while the sequencer is idle, and that `rd_req` is a single-tick pulse. The bench sets the attributes and `cfg_ready` before each access, pulses the request for one tick, and waits for `dir_ctl` to return high before the next scenario. `ext_rdy` is only raised during the active phase of an external-acknowledge bank, and it is cleared once that access ends.

// File: rtl/csrs_pkg.sv
package csrs_pkg;
    localparam int ATTR_W = 9;

    typedef struct packed {
        logic       ext_ack;
        logic       xhold;
        logic       relax;
        logic [3:0] wait_cnt;
        logic [1:0] cs_dly;
    } bank_attr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CSDLY,
        ST_ACTIVE,
        ST_ACK,
        ST_HOLD,
        ST_TURN
    } seq_state_t;
endpackage

// File: rtl/csrs_attr_sel.sv
module csrs_attr_sel
    import csrs_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BANK_W = 2,
    parameter logic [ATTR_W-1:0] BOOT_ATTR = 9'b0_1_0_0011_11
) (
    input  logic                    cfg_ready,
    input  logic [NBANK*ATTR_W-1:0] bank_cfg,
    input  logic [BANK_W-1:0]       bank,
    output bank_attr_t              attr
);
    bank_attr_t slot [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_slot
        if (g == 0) begin : g_boot
            assign slot[g] = cfg_ready ? bank_attr_t'(bank_cfg[ATTR_W-1:0])
                                       : bank_attr_t'(BOOT_ATTR);
        end else begin : g_cfg
            assign slot[g] = bank_attr_t'(bank_cfg[g*ATTR_W +: ATTR_W]);
        end
    end

    assign attr = slot[bank];
endmodule

// File: rtl/csrs_cs_decode.sv
module csrs_cs_decode #(
    parameter int NBANK = 4,
    parameter int BANK_W = 2
) (
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  cs_n
);
    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign cs_n[g] = !(en && (bank == BANK_W'(g)));
    end
endmodule

// File: rtl/csrs_capture.sv
module csrs_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= bus_in;
        end
    end

    // R8
    valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rd_valid);
endmodule

// File: rtl/csrs_top.sv
module csrs_top
    import csrs_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int DW = 8,
    parameter int PH = 4,
    parameter logic [ATTR_W-1:0] BOOT_ATTR = 9'b0_1_0_0011_11,
    localparam int BANK_W = $clog2(NBANK),
    localparam int MAX_TICKS = PH * (1 + 2 * 15),
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_ready,
    input  logic [NBANK*ATTR_W-1:0] bank_cfg,
    input  logic                    rd_req,
    input  logic [BANK_W-1:0]       rd_bank,
    input  logic                    ext_rdy,
    input  logic [DW-1:0]           bus_in,
    output logic                    ale,
    output logic [NBANK-1:0]        cs_n,
    output logic                    oe_n,
    output logic                    dir_ctl,
    output logic                    xfer_ack,
    output logic [DW-1:0]           rd_data,
    output logic                    rd_valid
);
    seq_state_t        state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    bank_attr_t        sel_attr, cur;
    logic [BANK_W-1:0] bank_q;
    logic              cs_en;
    int                dly_ticks, wait_ticks;

    csrs_attr_sel #(.NBANK(NBANK), .BANK_W(BANK_W), .BOOT_ATTR(BOOT_ATTR)) u_sel (
        .cfg_ready(cfg_ready), .bank_cfg(bank_cfg), .bank(rd_bank), .attr(sel_attr)
    );

    csrs_cs_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .en(cs_en), .bank(bank_q), .cs_n(cs_n)
    );

    csrs_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(xfer_ack), .bus_in(bus_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always_comb begin
        unique case (cur.cs_dly)
            2'b10:   dly_ticks = PH / 4;
            2'b11:   dly_ticks = PH / 2;
            default: dly_ticks = 0;
        endcase
        if (cur.ext_ack)    wait_ticks = PH;
        else if (cur.relax) wait_ticks = PH * (1 + 2 * int'(cur.wait_cnt));
        else                wait_ticks = PH * (1 + int'(cur.wait_cnt));
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = (cnt != '0) ? cnt - 1'b1 : cnt;
        unique case (state)
            ST_IDLE: if (rd_req) begin
                state_nxt = ST_ADDR;
                cnt_nxt   = CNT_W'(PH - 1);
            end
            ST_ADDR: if (cnt == '0) begin
                if (dly_ticks != 0) begin
                    state_nxt = ST_CSDLY;
                    cnt_nxt   = CNT_W'(dly_ticks - 1);
                end else begin
                    state_nxt = ST_ACTIVE;
                    cnt_nxt   = CNT_W'(wait_ticks - 1);
                end
            end
            ST_CSDLY: if (cnt == '0) begin
                state_nxt = ST_ACTIVE;
                cnt_nxt   = CNT_W'(wait_ticks - 1);
            end
            ST_ACTIVE: if (cnt == '0) begin
                if (cur.ext_ack && !ext_rdy) cnt_nxt = CNT_W'(PH - 1);
                else                         state_nxt = ST_ACK;
            end
            ST_ACK: begin
                if (cur.xhold) begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = CNT_W'(PH - 1);
                end else begin
                    state_nxt = ST_TURN;
                end
            end
            ST_HOLD: if (cnt == '0) state_nxt = ST_TURN;
            ST_TURN: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cur    <= '0;
            bank_q <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (state == ST_IDLE && rd_req) begin
                cur    <= sel_attr;
                bank_q <= rd_bank;
            end
        end
    end

    always_comb begin
        ale      = 1'b0;
        dir_ctl  = 1'b0;
        cs_en    = 1'b0;
        xfer_ack = 1'b0;
        unique case (state)
            ST_IDLE:   dir_ctl = 1'b1;
            ST_ADDR:   begin ale = 1'b1; dir_ctl = 1'b1; end
            ST_CSDLY:  ;
            ST_ACTIVE: cs_en = 1'b1;
            ST_ACK:    begin cs_en = 1'b1; xfer_ack = 1'b1; end
            ST_HOLD:   ;
            ST_TURN:   ;
            default:   dir_ctl = 1'b1;
        endcase
        oe_n = !cs_en;
    end

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R5
    oe_cs_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n == (&cs_n));
    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack);
    // R8
    ack_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> !(&cs_n));
    // R2
    ale_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> dir_ctl);
    // R3
    cs_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> (!ale && !dir_ctl));
    // R9
    turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_ctl) |-> (&cs_n));
endmodule

// File: tb/tb_csrs_top.sv
module tb_csrs_top;
    localparam int NB = 4;
    localparam int PH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_ready = 1'b0;
    logic [NB*9-1:0] bank_cfg = '0;
    logic            rd_req = 1'b0;
    logic [1:0]      rd_bank = '0;
    logic            ext_rdy = 1'b0;
    logic [7:0]      bus_in = '0;
    logic            ale, oe_n, dir_ctl, xfer_ack, rd_valid;
    logic [NB-1:0]   cs_n;
    logic [7:0]      rd_data;
    int              total = 0;
    int              bad = 0;

    always #2 clk = ~clk;

    csrs_top #(.NBANK(NB), .DW(8), .PH(PH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .bank_cfg(bank_cfg),
        .rd_req(rd_req), .rd_bank(rd_bank), .ext_rdy(ext_rdy), .bus_in(bus_in),
        .ale(ale), .cs_n(cs_n), .oe_n(oe_n), .dir_ctl(dir_ctl),
        .xfer_ack(xfer_ack), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic run_access(input string nm, input string wrq, input int bank,
                              input int rdy_at, input logic [7:0] pat,
                              input int e_gap, input int e_act, input int e_tail);
        int n_ale = 0, gap = 0, act = 0, ackw = 0, tail = 0, nval = 0, guard = 0;
        int oth_bad = 0, oe_bad = 0, dat_bad = 0;
        bit started = 0, done = 0;
        @(negedge clk);
        bus_in  = pat;
        rd_bank = 2'(bank);
        ext_rdy = (rdy_at == 0);
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (!done && guard < 1000) begin
            if (ale) n_ale++;
            else if (!dir_ctl) begin
                started = 1;
                if (&cs_n) begin
                    if (ackw == 0) gap++;
                    else tail++;
                end else begin
                    if (xfer_ack) ackw++;
                    else act++;
                    if (rdy_at > 0 && act == rdy_at) ext_rdy = 1'b1;
                    if (cs_n[bank]) oth_bad++;
                end
            end else if (started) done = 1;
            for (int b = 0; b < NB; b++)
                if (b != bank && !cs_n[b]) oth_bad++;
            if (oe_n != (&cs_n)) oe_bad++;
            if (rd_valid) begin
                nval++;
                if (rd_data !== pat) dat_bad++;
            end
            if (!done) begin
                @(negedge clk);
                guard++;
            end
        end
        ext_rdy = 1'b0;
        $display("scenario %s", nm);
        chk("R2", "ale ticks", n_ale, PH);
        chk("R3", "cs delay ticks", gap, e_gap);
        chk(wrq, "active ticks", act, e_act);
        chk("R8", "ack width", ackw, 1);
        chk("R8", "valid pulses", nval, 1);
        chk("R8", "data mismatches", dat_bad, 0);
        chk("R9", "tail ticks", tail, e_tail);
        chk("R4", "wrong chip-select ticks", oth_bad, 0);
        chk("R5", "oe mismatch ticks", oe_bad, 0);
        chk("R9", "dir_ctl high at end", int'(dir_ctl), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "cs_n", int'(cs_n), 15);
        chk("R1", "oe_n", int'(oe_n), 1);
        chk("R1", "ale", int'(ale), 0);
        chk("R1", "dir_ctl", int'(dir_ctl), 1);
        chk("R1", "xfer_ack", int'(xfer_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rd_valid after reset", int'(rd_valid), 0);
        chk("R1", "cs_n after reset", int'(cs_n), 15);
    endtask

    // bank field layout: [8] ext ack, [7] hold, [6] relax, [5:2] wait, [1:0] delay
    task automatic t_boot();
        cfg_ready = 1'b0;
        run_access("boot default bank0 R10", "R10", 0, -1, 8'hA5, 2, 16, 5);
    endtask

    task automatic t_cfg_bank0();
        cfg_ready = 1'b1;
        run_access("configured bank0 R10", "R6", 0, -1, 8'h3C, 0, 4, 1);
    endtask

    task automatic t_relax();
        run_access("relaxed bank1", "R6", 1, -1, 8'h5A, 1, 20, 1);
    endtask

    task automatic t_ext();
        run_access("ext ack late", "R7", 2, 6, 8'hC3, 0, 8, 1);
        run_access("ext ack early", "R7", 2, 0, 8'h0F, 0, 4, 1);
        run_access("ext ack later", "R7", 2, 9, 8'hF0, 0, 12, 1);
    endtask

    task automatic t_hold();
        run_access("hold bank3 delay 01", "R6", 3, -1, 8'h99, 0, 8, 5);
        cfg_ready = 1'b0;
        run_access("bank3 unaffected by boot R10", "R10", 3, -1, 8'h66, 0, 8, 5);
    endtask

    initial begin
        bank_cfg[0*9 +: 9] = 9'b0_0_0_0000_00;
        bank_cfg[1*9 +: 9] = 9'b0_0_1_0010_10;
        bank_cfg[2*9 +: 9] = 9'b1_0_0_1111_00;
        bank_cfg[3*9 +: 9] = 9'b0_1_0_0001_01;
        t_reset();
        t_boot();
        t_cfg_bank0();
        t_relax();
        t_ext();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule